// File: doc/BRIEF.md
# Custom 64-bit Integer Extension Unit

This unit executes a small group of extra 64-bit integer operations that share one major opcode. Each cycle it may accept one 32-bit instruction word together with the values already read for its two source registers, `src_s` and `src_t`. It decodes the word, computes the result and presents it one clock later with the index of the destination register, a write strobe and an illegal-instruction flag. The surrounding pipeline owns the register file, the forwarding and the hazards. It writes `res_data` into register `res_dest` whenever `res_we` is high.

The operations are a byte-wide add, the low half of a 64-bit multiply, a signed bitfield extract, a bitfield insert into a cleared word, a population count over 32 or 64 bits, and equality and inequality tests against a register or a signed immediate. The unit ignores words whose major opcode is not its own. A word inside its opcode that fits none of the defined encodings is reported as illegal.

Top module: `ext_alu64`

## Requirements
- R1: Only words with bits [31:26] = 011100 are handled. Any other word yields `res_we` = 0 and `res_illegal` = 0 in the following cycle.
- R2: Outputs are registered with exactly one cycle of latency after a cycle with `in_valid` high. After a cycle with `in_valid` low, `res_we` and `res_illegal` are 0.
- R3: Byte add ([10:0] = 00000101000, rs in [25:21], rt in [20:16], rd in [15:11]) writes the low 8 bits of src_s + src_t, zero-extended, to rd.
- R4: Multiply ([10:0] = 00000000011, same register fields) writes the low 64 bits of src_s × src_t to rd.
- R5: Signed extract (bits [5:1] = 11101) uses lenm1 = [15:11], p = [10:6] and shift bit [0]. The effective position is p + 32·shift. It writes to rt ([20:16]) the lenm1+1 bits of src_s starting at that position, right-aligned and sign-extended from bit lenm1.
- R6: Insert (bits [5:1] = 11001) writes to rt the low lenm1+1 bits of src_s shifted left by the effective position. All other result bits are zero.
- R7: Popcount ([20:16] = 0, [10:6] = 0, [5:1] = 10110) writes to rd the count of ones in src_s. When bit [0] = 0 only bits [31:0] are counted; when bit [0] = 1 all 64 bits are counted.
- R8: Register compare ([10:6] = 0, [5:1] = 10101) writes 1 to rd when src_s equals src_t (bit [0] = 0) or differs from it (bit [0] = 1), and 0 otherwise.
- R9: Immediate compare ([5:1] = 10111) sign-extends the 10-bit immediate in [15:6] and compares it with src_s in the same way as R8, under bit [0]. It writes 1 or 0 to rt.
- R10: A defined instruction whose destination index is 0 gives `res_we` = 0 and `res_illegal` = 0.
- R11: A word with opcode 011100 that matches no defined encoding, including one with a nonzero must-be-zero field, gives `res_illegal` = 1 and `res_we` = 0 for one cycle.
- R12: For extract and insert, field bits that would lie above bit 63 are dropped without a fault. Extract reads them as zero.
- R13: Synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_instr | input | 32 | Instruction word |
| src_s | input | 64 | Value of the register named by [25:21] |
| src_t | input | 64 | Value of the register named by [20:16] |
| res_data | output | 64 | Result |
| res_dest | output | 5 | Destination register index |
| res_we | output | 1 | Write strobe for the register file |
| res_illegal | output | 1 | Undefined word inside the unit's opcode |

## Verification
Extract and insert are swept over every length, position and shift bit. This catches three faults: a mask that wraps to zero at length 32, a position bias applied the wrong way, and sign extension taken from the wrong bit. Each of these shows up as wrong upper bits or as a field that disappears. Fields that cross bit 63 are included, so a design that wraps those bits around or sign-fills from garbage returns the wrong value. The immediate compare is run over all 1024 immediates, which exposes a zero-extended immediate on every negative value. The byte add is given carries out of bit 7, the popcount is given words with ones only in the upper half, and the bench sends must-be-zero violations and destination-zero cases. A unit that leaks high sum bits, ignores the width flag or writes register 0 therefore produces the wrong data or a wrong strobe.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;

    localparam int XLEN   = 64;
    localparam int REGW   = 5;
    localparam int POSW   = $clog2(XLEN);
    localparam int CNTW   = $clog2(XLEN) + 1;
    localparam int IMMW   = 10;

    localparam logic [5:0]  MAJOR_OP   = 6'b011100;
    localparam logic [10:0] TAIL_BADD  = 11'b00000_101000;
    localparam logic [10:0] TAIL_MUL   = 11'b00000_000011;
    localparam logic [4:0]  FN_SEXT    = 5'b11101;
    localparam logic [4:0]  FN_INS     = 5'b11001;
    localparam logic [4:0]  FN_POPC    = 5'b10110;
    localparam logic [4:0]  FN_CMP     = 5'b10101;
    localparam logic [4:0]  FN_CMPI    = 5'b10111;

    typedef enum logic [2:0] {
        K_NONE, K_BADD, K_MUL, K_SEXT, K_INS, K_POPC, K_CMP, K_CMPI
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic              ours;
        logic [REGW-1:0]   dest;
        logic [4:0]        lenm1;
        logic [POSW-1:0]   epos;
        logic              flag;
        logic [IMMW-1:0]   imm;
    } dec_t;

    function automatic logic [CNTW-1:0] count_ones(input logic [XLEN-1:0] v);
        logic [CNTW-1:0] acc;
        acc = '0;
        for (int i = 0; i < XLEN; i++) acc = acc + CNTW'(v[i]);
        return acc;
    endfunction

endpackage

// File: rtl/ext_alu_decode.sv
module ext_alu_decode
    import ext_alu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [4:0] fn;
    logic       mbz_mid;
    logic       mbz_rt;

    assign fn      = instr[5:1];
    assign mbz_mid = (instr[10:6] == 5'd0);
    assign mbz_rt  = (instr[20:16] == 5'd0);

    always_comb begin
        dec.kind  = K_NONE;
        dec.ours  = (instr[31:26] == MAJOR_OP);
        dec.dest  = instr[15:11];
        dec.lenm1 = instr[15:11];
        dec.epos  = {instr[0], instr[10:6]};
        dec.flag  = instr[0];
        dec.imm   = instr[15:6];
        if (dec.ours) begin
            if (instr[10:0] == TAIL_BADD) begin
                dec.kind = K_BADD;
            end else if (instr[10:0] == TAIL_MUL) begin
                dec.kind = K_MUL;
            end else if (fn == FN_SEXT) begin
                dec.kind = K_SEXT;
                dec.dest = instr[20:16];
            end else if (fn == FN_INS) begin
                dec.kind = K_INS;
                dec.dest = instr[20:16];
            end else if (fn == FN_POPC && mbz_mid && mbz_rt) begin
                dec.kind = K_POPC;
            end else if (fn == FN_CMP && mbz_mid) begin
                dec.kind = K_CMP;
            end else if (fn == FN_CMPI) begin
                dec.kind = K_CMPI;
                dec.dest = instr[20:16];
            end
        end
    end
endmodule

// File: rtl/ext_alu_bitfield.sv
module ext_alu_bitfield
    import ext_alu_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [4:0]      lenm1,
    input  logic [POSW-1:0] epos,
    output logic [XLEN-1:0] extracted,
    output logic [XLEN-1:0] inserted
);
    logic [5:0]      len;
    logic [XLEN-1:0] lmask;
    logic [XLEN-1:0] field;

    assign len   = {1'b0, lenm1} + 6'd1;
    assign lmask = (XLEN'(1) << len) - XLEN'(1);
    assign field = (src >> epos) & lmask;

    always_comb begin
        extracted = field;
        if (field[lenm1]) extracted = field | ~lmask;
    end

    assign inserted = (src & lmask) << epos;
endmodule

// File: rtl/ext_alu_exec.sv
module ext_alu_exec
    import ext_alu_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] bf_ext;
    logic [XLEN-1:0] bf_ins;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] pop_src;
    logic            eq_r;
    logic            eq_i;

    ext_alu_bitfield u_bf (
        .src       (opa),
        .lenm1     (dec.lenm1),
        .epos      (dec.epos),
        .extracted (bf_ext),
        .inserted  (bf_ins)
    );

    assign sum     = opa + opb;
    assign prod    = opa * opb;
    assign imm_x   = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
    assign eq_r    = (opa == opb);
    assign eq_i    = (opa == imm_x);
    assign pop_src = dec.flag ? opa : {{(XLEN/2){1'b0}}, opa[XLEN/2-1:0]};

    always_comb begin
        unique case (dec.kind)
            K_BADD:  result = {{(XLEN-8){1'b0}}, sum[7:0]};
            K_MUL:   result = prod;
            K_SEXT:  result = bf_ext;
            K_INS:   result = bf_ins;
            K_POPC:  result = XLEN'(count_ones(pop_src));
            K_CMP:   result = XLEN'(eq_r ^ dec.flag);
            K_CMPI:  result = XLEN'(eq_i ^ dec.flag);
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/ext_alu64.sv
module ext_alu64
    import ext_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [63:0]     src_s,
    input  logic [63:0]     src_t,
    output logic [63:0]     res_data,
    output logic [4:0]      res_dest,
    output logic            res_we,
    output logic            res_illegal
);
    dec_t            dec;
    logic [XLEN-1:0] result;
    logic            known;

    ext_alu_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    ext_alu_exec u_exec (
        .dec    (dec),
        .opa    (src_s),
        .opb    (src_t),
        .result (result)
    );

    assign known = (dec.kind != K_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data    <= '0;
            res_dest    <= '0;
            res_we      <= 1'b0;
            res_illegal <= 1'b0;
        end else begin
            res_we      <= in_valid && known && (dec.dest != '0);
            res_illegal <= in_valid && dec.ours && !known;
            if (in_valid && known) begin
                res_data <= result;
                res_dest <= dec.dest;
            end
        end
    end
endmodule

// File: rtl/ext_alu64_chk.sv
module ext_alu64_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_instr,
    input logic [63:0] src_s,
    input logic [63:0] src_t,
    input logic [63:0] res_data,
    input logic [4:0]  res_dest,
    input logic        res_we,
    input logic        res_illegal
);
    logic mine;
    assign mine = in_valid && (in_instr[31:26] == 6'b011100);

    assert_foreign_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[31:26] != 6'b011100) |=> (!res_we && !res_illegal));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_we && !res_illegal));

    assert_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (mine && in_instr[10:0] == 11'b00000101000) |=> (res_data[63:8] == 56'd0));

    assert_popcnt_R7: assert property (@(posedge clk) disable iff (rst)
        (mine && in_instr[20:16] == 5'd0 && in_instr[10:6] == 5'd0 && in_instr[5:1] == 5'b10110)
        |=> (res_data <= 64'd64));

    assert_cmp_R8: assert property (@(posedge clk) disable iff (rst)
        (mine && in_instr[10:6] == 5'd0 && in_instr[5:1] == 5'b10101) |=> (res_data[63:1] == 63'd0));

    assert_cmpi_R9: assert property (@(posedge clk) disable iff (rst)
        (mine && in_instr[5:1] == 5'b10111) |=> (res_data[63:1] == 63'd0));

    assert_zero_dest_R10: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_dest != 5'd0));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(res_we && res_illegal));
endmodule

bind ext_alu64 ext_alu64_chk i_chk (.*);

// File: tb/test_ext_alu64.sv
`timescale 1ns/1ps
module test_ext_alu64;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] src_s = '0;
    logic [63:0] src_t = '0;
    logic [63:0] res_data;
    logic [4:0]  res_dest;
    logic        res_we;
    logic        res_illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_alu64 i_ext_alu64 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .src_s(src_s), .src_t(src_t), .res_data(res_data), .res_dest(res_dest),
        .res_we(res_we), .res_illegal(res_illegal)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic run(input string tag, input logic v, input logic [31:0] w,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic ewe, input logic eill, input logic [4:0] edst,
                       input logic [63:0] eres, input bit chkres);
        @(negedge clk);
        in_valid = v; in_instr = w; src_s = a; src_t = b;
        @(negedge clk);
        in_valid = 1'b0;
        cmp({tag, " we"}, 64'(res_we), 64'(ewe));
        cmp({tag, " illegal"}, 64'(res_illegal), 64'(eill));
        if (ewe) cmp({tag, " dest"}, 64'(res_dest), 64'(edst));
        if (chkres) cmp({tag, " data"}, res_data, eres);
    endtask

    function automatic logic [31:0] r3(input logic [4:0] rd, input logic [10:0] tail);
        return {6'b011100, 5'd3, 5'd4, rd, tail};
    endfunction

    function automatic logic [31:0] bf(input logic [4:0] rt, input logic [4:0] lenm1,
                                       input logic [4:0] p, input logic [4:0] fn, input logic sh);
        return {6'b011100, 5'd2, rt, lenm1, p, fn, sh};
    endfunction

    function automatic logic [63:0] m_ext(input logic [63:0] v, input int lenm1, input int ep);
        logic [63:0] r = '0;
        for (int i = 0; i <= lenm1; i++) if (ep + i < 64) r[i] = v[ep + i];
        for (int i = lenm1 + 1; i < 64; i++) r[i] = r[lenm1];
        return r;
    endfunction

    function automatic logic [63:0] m_ins(input logic [63:0] v, input int lenm1, input int ep);
        logic [63:0] r = '0;
        for (int i = 0; i <= lenm1; i++) if (ep + i < 64) r[ep + i] = v[i];
        return r;
    endfunction

    function automatic logic [63:0] m_pop(input logic [63:0] v, input bit dw);
        int n = 0;
        for (int i = 0; i < (dw ? 64 : 32); i++) n += int'(v[i]);
        return 64'(n);
    endfunction

    initial begin
        logic [63:0] data [4];
        data[0] = 64'hF0E1_D2C3_B4A5_9687;
        data[1] = 64'h0123_4567_89AB_CDEF;
        data[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        data[3] = 64'h8000_0000_0000_0001;

        repeat (3) @(negedge clk);
        // R13: reset state
        cmp("R13 data", res_data, 64'd0);
        cmp("R13 we", 64'(res_we), 64'd0);
        cmp("R13 illegal", 64'(res_illegal), 64'd0);
        cmp("R13 dest", 64'(res_dest), 64'd0);
        rst = 1'b0;

        // R1: every foreign major opcode is ignored
        for (int op = 0; op < 64; op++) begin
            if (op == 6'b011100) continue;
            run("R1 foreign", 1'b1, {6'(op), 5'd1, 5'd2, 5'd7, 11'b00000101000},
                64'd1, 64'd2, 1'b0, 1'b0, 5'd0, 64'd0, 1'b0);
        end

        // R3: byte add, carries and high bits dropped
        run("R3 badd", 1'b1, r3(5'd9, 11'b00000101000), 64'hFF, 64'h01, 1'b1, 1'b0, 5'd9, 64'd0, 1'b1);
        run("R3 badd", 1'b1, r3(5'd31, 11'b00000101000), 64'hFFFF_0000_0000_1280, 64'h7700_0000_0000_0093,
            1'b1, 1'b0, 5'd31, 64'h13, 1'b1);
        for (int k = 0; k < 4; k++)
            run("R3 badd", 1'b1, r3(5'd5, 11'b00000101000), data[k], data[(k+1)%4],
                1'b1, 1'b0, 5'd5, {56'd0, 8'(data[k][7:0] + data[(k+1)%4][7:0])}, 1'b1);

        // R4: multiply low
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 4; j++) begin
                logic [127:0] full;
                full = {64'd0, data[k]} * {64'd0, data[j]};
                run("R4 mul", 1'b1, r3(5'd12, 11'b00000000011), data[k], data[j],
                    1'b1, 1'b0, 5'd12, full[63:0], 1'b1);
            end
        run("R4 mul", 1'b1, r3(5'd1, 11'b00000000011), 64'hFFFF_FFFF_FFFF_FFFD, 64'd7,
            1'b1, 1'b0, 5'd1, 64'hFFFF_FFFF_FFFF_FFEB, 1'b1);

        // R5/R6/R12: full sweep of length, position and shift bit
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 32; l++)
                for (int ep = 0; ep < 64; ep++) begin
                    run((ep + l > 63) ? "R12 sext" : "R5 sext", 1'b1,
                        bf(5'd6, 5'(l), 5'(ep % 32), 5'b11101, ep >= 32), data[d], 64'd0,
                        1'b1, 1'b0, 5'd6, m_ext(data[d], l, ep), 1'b1);
                    run((ep + l > 63) ? "R12 ins" : "R6 ins", 1'b1,
                        bf(5'd17, 5'(l), 5'(ep % 32), 5'b11001, ep >= 32), data[d], 64'd0,
                        1'b1, 1'b0, 5'd17, m_ins(data[d], l, ep), 1'b1);
                end

        // R7: popcount, both widths
        for (int k = 0; k < 4; k++)
            for (int dw = 0; dw < 2; dw++)
                run("R7 pop", 1'b1, {6'b011100, 5'd8, 5'd0, 5'd20, 5'd0, 5'b10110, 1'(dw)},
                    data[k], 64'd0, 1'b1, 1'b0, 5'd20, m_pop(data[k], dw), 1'b1);
        run("R7 pop upper", 1'b1, {6'b011100, 5'd8, 5'd0, 5'd20, 5'd0, 5'b10110, 1'b0},
            64'hFFFF_FFFF_0000_0000, 64'd0, 1'b1, 1'b0, 5'd20, 64'd0, 1'b1);

        // R8: register compare
        for (int ne = 0; ne < 2; ne++) begin
            run("R8 cmp same", 1'b1, {6'b011100, 5'd1, 5'd2, 5'd3, 5'd0, 5'b10101, 1'(ne)},
                data[0], data[0], 1'b1, 1'b0, 5'd3, 64'(ne == 0), 1'b1);
            run("R8 cmp diff", 1'b1, {6'b011100, 5'd1, 5'd2, 5'd3, 5'd0, 5'b10101, 1'(ne)},
                data[0], data[0] ^ 64'h8000_0000_0000_0000, 1'b1, 1'b0, 5'd3, 64'(ne == 1), 1'b1);
        end

        // R9: every immediate, matching and off-by-one operands
        for (int im = 0; im < 1024; im++) begin
            logic [63:0] sx;
            sx = {{54{im[9]}}, 10'(im)};
            run("R9 cmpi eq", 1'b1, {6'b011100, 5'd1, 5'd11, 10'(im), 5'b10111, 1'b0},
                sx, 64'd0, 1'b1, 1'b0, 5'd11, 64'd1, 1'b1);
            run("R9 cmpi ne", 1'b1, {6'b011100, 5'd1, 5'd11, 10'(im), 5'b10111, 1'b1},
                sx ^ 64'h0100_0000_0000_0000, 64'd0, 1'b1, 1'b0, 5'd11, 64'd1, 1'b1);
        end

        // R10: destination zero
        run("R10 badd rd0", 1'b1, r3(5'd0, 11'b00000101000), 64'd1, 64'd1, 1'b0, 1'b0, 5'd0, 64'd0, 1'b0);
        run("R10 sext rt0", 1'b1, bf(5'd0, 5'd3, 5'd1, 5'b11101, 1'b0), 64'hF, 64'd0, 1'b0, 1'b0, 5'd0, 64'd0, 1'b0);
        run("R10 cmpi rt0", 1'b1, {6'b011100, 5'd1, 5'd0, 10'd0, 5'b10111, 1'b0}, 64'd0, 64'd0,
            1'b0, 1'b0, 5'd0, 64'd0, 1'b0);

        // R11: undefined encodings inside the opcode
        run("R11 badd mbz", 1'b1, r3(5'd9, 11'b00100101000), 64'd1, 64'd1, 1'b0, 1'b1, 5'd0, 64'd0, 1'b0);
        run("R11 pop rt", 1'b1, {6'b011100, 5'd8, 5'd1, 5'd20, 5'd0, 5'b10110, 1'b1}, 64'd1, 64'd0,
            1'b0, 1'b1, 5'd0, 64'd0, 1'b0);
        run("R11 cmp mbz", 1'b1, {6'b011100, 5'd1, 5'd2, 5'd3, 5'd4, 5'b10101, 1'b0}, 64'd1, 64'd1,
            1'b0, 1'b1, 5'd0, 64'd0, 1'b0);
        run("R11 fn", 1'b1, {6'b011100, 5'd1, 5'd2, 5'd3, 5'd0, 5'b11111, 1'b1}, 64'd1, 64'd1,
            1'b0, 1'b1, 5'd0, 64'd0, 1'b0);

        // R2: one-cycle pulse, idle input ignored, data held
        run("R2 idle", 1'b0, {6'b011100, 5'd1, 5'd2, 5'd3, 5'd0, 5'b11111, 1'b1}, 64'd1, 64'd1,
            1'b0, 1'b0, 5'd0, 64'd0, 1'b0);
        run("R2 latency", 1'b1, r3(5'd7, 11'b00000101000), 64'h10, 64'h20, 1'b1, 1'b0, 5'd7, 64'h30, 1'b1);
        run("R2 idle legal", 1'b0, r3(5'd8, 11'b00000101000), 64'h1, 64'h1, 1'b0, 1'b0, 5'd0, 64'h30, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule